// File: doc/BRIEF.md
# Status Capture Register with Clear-on-Read

This block collects up to eight status lines into one register that a processor can read. It runs on the fast bus clock, which is much faster than the signals it watches. Each bit is set up on its own to work in one of three ways:

- **Level-hold:** the bit latches whenever its line is high.
- **Rising-edge hold:** the bit latches only on a low-to-high step of its line.
- **Live:** the bit shows the current line value with nothing stored.

A single-cycle read strobe returns the register value on the data port. At the end of that cycle the strobe clears the held bits.

A level-held line that stays high through a read sets its bit again on the next clock. Rising-edge hold exists for that case. A long pulse is reported once, and after a read it stays cleared until the line drops and rises again.

An interrupt output summarises the held bits that a per-bit mask lets through.

Top module: `status_capture_reg`

## Requirements
- R1: A synchronous active-high reset clears every held bit and every previous-input register. Right after reset, held bits read 0 and `irq` is 0.
- R2: A bit in level-hold mode (mode code 2'b00 in `mode_cfg[2i+1:2i]`) is set by a clock edge at which its input is 1. It stays 1 after the input falls until a read clears it.
- R3: `rd_data` shows the register view in the same cycle as `rd_stb`. At the end of a strobed cycle, every held bit whose set condition is false becomes 0.
- R4: A level-hold bit whose input is still 1 in the read cycle stays set after the read.
- R5: A bit in live mode (codes 2'b01 and 2'b11) drives `rd_data` with its current input and never latches. Its held flag is 0 from the cycle after live mode is selected, so it adds nothing to `irq`.
- R6: A bit in rising-edge mode (code 2'b10) is set only at an edge where its input is 1 and the input sampled at the previous edge was 0. An input held high after a clear does not set it again.
- R7: When a set condition and a read strobe fall in the same cycle, the bit is 1 afterwards.
- R8: `irq` equals the OR over all bits of (held bit AND `irq_mask` bit), taken from the registered held bits. After a read in a cycle with no set condition, it is 0 in the next cycle.
- R9: A 0 in `irq_mask` keeps its bit out of `irq` but does not stop the bit from being captured and read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_in | input | WIDTH | Status lines being watched |
| mode_cfg | input | 2*WIDTH | Two-bit capture mode per bit |
| irq_mask | input | WIDTH | Per-bit interrupt enable |
| rd_stb | input | 1 | One-cycle read strobe; clears held bits |
| rd_data | output | WIDTH | Register view: held bits, or live input in live mode |
| irq | output | 1 | Interrupt: any enabled held bit set |

## Verification
The hardest case to reach is a read strobe that lands in the same cycle as a set condition, in particular a rising edge arriving exactly in the read cycle. Only that case separates "set wins" from "clear wins". The bench steers there with directed sequences: it raises an edge-mode line in the very cycle it strobes the read, and it holds a level-mode line high across a read. A long random phase then mixes strobes, mode changes and mask changes, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/stat_cap_pkg.sv
package stat_cap_pkg;

    typedef enum logic [1:0] {
        CAP_LEVEL    = 2'b00,
        CAP_LIVE     = 2'b01,
        CAP_RISE     = 2'b10,
        CAP_LIVE_ALT = 2'b11
    } cap_mode_e;

    typedef struct packed {
        logic held;
        logic view;
    } cell_out_t;

    function automatic logic mode_is_live(input cap_mode_e m);
        return (m == CAP_LIVE) || (m == CAP_LIVE_ALT);
    endfunction

endpackage

// File: rtl/stat_cap_cell.sv
module stat_cap_cell
    import stat_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  cap_mode_e mode,
    input  logic      rd_clr,
    output cell_out_t q
);
    logic prev_q;
    logic held_q;
    logic live;
    logic set_cond;

    always_comb begin
        live = mode_is_live(mode);
        unique case (mode)
            CAP_LEVEL: set_cond = din;
            CAP_RISE:  set_cond = din & ~prev_q;
            default:   set_cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= din;
            if (live)
                held_q <= 1'b0;
            else if (set_cond)
                held_q <= 1'b1;
            else if (rd_clr)
                held_q <= 1'b0;
        end
    end

    always_comb begin
        q.held = held_q;
        q.view = live ? din : held_q;
    end

    assert_level_set_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_LEVEL && din) |=> held_q);

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !din) |=> !held_q);

    assert_live_nohold_R5: assert property (@(posedge clk) disable iff (rst)
        live |=> !held_q);

    assert_no_level_retrigger_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_RISE && prev_q && din && !held_q) |=> !held_q);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && din && mode == CAP_RISE && !prev_q) |=> held_q);

endmodule

// File: rtl/stat_irq_reduce.sv
module stat_irq_reduce #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] held,
    input  logic [WIDTH-1:0] mask,
    output logic             irq
);
    assign irq = |(held & mask);
endmodule

// File: rtl/status_capture_reg.sv
module status_capture_reg
    import stat_cap_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   stat_in,
    input  logic [2*WIDTH-1:0] mode_cfg,
    input  logic [WIDTH-1:0]   irq_mask,
    input  logic               rd_stb,
    output logic [WIDTH-1:0]   rd_data,
    output logic               irq
);
    localparam int MODE_W = 2;

    logic [WIDTH-1:0] held_vec;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        cell_out_t co;
        stat_cap_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .din    (stat_in[i]),
            .mode   (cap_mode_e'(mode_cfg[MODE_W*i +: MODE_W])),
            .rd_clr (rd_stb),
            .q      (co)
        );
        assign held_vec[i] = co.held;
        assign rd_data[i]  = co.view;
    end

    stat_irq_reduce #(.WIDTH(WIDTH)) u_irq (
        .held (held_vec),
        .mask (irq_mask),
        .irq  (irq)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (held_vec == '0 && !irq));

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && stat_in == '0) |=> !irq);

    assert_mask_block_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !irq);

endmodule

// File: tb/status_capture_reg_test.sv
module status_capture_reg_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] stat_in;
    logic [2*W-1:0] mode_cfg;
    logic [W-1:0] irq_mask;
    logic         rd_stb;
    logic [W-1:0] rd_data;
    logic         irq;

    int vectors = 0;
    int errors  = 0;
    int m_held[W];
    int m_prev[W];
    bit done = 0;

    always #4 clk = ~clk;

    status_capture_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .stat_in(stat_in), .mode_cfg(mode_cfg),
        .irq_mask(irq_mask), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    function automatic int mode_of(int i);
        return int'(mode_cfg[2*i +: 2]);
    endfunction

    task automatic set_mode(input int i, input logic [1:0] m);
        mode_cfg[2*i +: 2] = m;
    endtask

    task automatic apply(input logic [W-1:0] din, input logic rd, input string tag);
        logic [W-1:0] exp_rd;
        logic exp_irq;
        stat_in = din;
        rd_stb  = rd;
        #1;
        exp_irq = 1'b0;
        for (int i = 0; i < W; i++) begin
            int m = mode_of(i);
            bit live = (m == 1) || (m == 3);
            exp_rd[i] = live ? din[i] : (m_held[i] != 0);
            if (m_held[i] != 0 && irq_mask[i]) exp_irq = 1'b1;
        end
        vectors++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data actual=%b expected=%b", tag, rd_data, exp_rd);
        end
        vectors++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
        end
        for (int i = 0; i < W; i++) begin
            int m = mode_of(i);
            bit live = (m == 1) || (m == 3);
            bit setc = (m == 0) ? din[i] : (m == 2) ? (din[i] && m_prev[i] == 0) : 1'b0;
            if (rst) begin
                m_held[i] = 0;
                m_prev[i] = 0;
            end else begin
                if (live) m_held[i] = 0;
                else if (setc) m_held[i] = 1;
                else if (rd) m_held[i] = 0;
                m_prev[i] = din[i];
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; stat_in = '0; mode_cfg = '0; irq_mask = '1; rd_stb = 1'b0;
        for (int i = 0; i < W; i++) begin m_held[i] = 0; m_prev[i] = 0; end
        @(negedge clk);
        // R1: reset with lines high, then first cycle out of reset
        repeat (3) apply(8'hFF, 1'b0, "R1");
        rst = 1'b0;
        apply(8'h00, 1'b0, "R1");
        // R2: one-cycle pulse is held
        apply(8'h01, 1'b0, "R2");
        repeat (3) apply(8'h00, 1'b0, "R2");
        // R3/R8: read clears, irq drops next cycle
        apply(8'h00, 1'b1, "R3");
        apply(8'h00, 1'b0, "R8");
        // R4: level still high through read
        apply(8'h02, 1'b0, "R4");
        apply(8'h02, 1'b1, "R4");
        apply(8'h02, 1'b0, "R4");
        apply(8'h00, 1'b1, "R4");
        apply(8'h00, 1'b0, "R4");
        // R5: live bits 2 (code 01) and 3 (code 11)
        set_mode(2, 2'b01); set_mode(3, 2'b11);
        apply(8'h04, 1'b0, "R5");
        apply(8'h08, 1'b0, "R5");
        apply(8'h0C, 1'b1, "R5");
        apply(8'h00, 1'b0, "R5");
        // R6: rising-edge bit 4 with a long pulse
        set_mode(4, 2'b10);
        apply(8'h00, 1'b0, "R6");
        apply(8'h10, 1'b0, "R6");
        apply(8'h10, 1'b1, "R6");
        apply(8'h10, 1'b0, "R6");
        apply(8'h10, 1'b0, "R6");
        apply(8'h00, 1'b0, "R6");
        apply(8'h10, 1'b0, "R6");
        apply(8'h00, 1'b1, "R6");
        // R7: rising edge in the read cycle, and level in the read cycle
        set_mode(5, 2'b10);
        apply(8'h00, 1'b0, "R7");
        apply(8'h60, 1'b1, "R7");
        apply(8'h00, 1'b0, "R7");
        apply(8'h00, 1'b1, "R7");
        apply(8'h00, 1'b0, "R7");
        // R9: masked capture
        irq_mask = 8'h00;
        apply(8'h01, 1'b0, "R9");
        apply(8'h00, 1'b0, "R9");
        irq_mask = 8'h01;
        apply(8'h00, 1'b0, "R9");
        apply(8'h00, 1'b1, "R9");
        irq_mask = '1;
        // R8: mixed random traffic
        for (int n = 0; n < 400; n++) begin
            if (n % 32 == 0) begin
                mode_cfg = 16'($urandom);
                irq_mask = 8'($urandom);
            end
            apply(8'($urandom) & 8'($urandom), ($urandom % 4) == 0, "R8");
        end
        done = 1;
        finish_run();
    end
endmodule